// File: doc/BRIEF.md
# Bitwise Lookup-Table Logic Unit

This unit evaluates an arbitrary bitwise boolean function over general-purpose register operands. Every result bit is drawn from a small truth table, and the index into that table is made from the operand bits at the same position. All positions are evaluated in parallel. The result is registered, so it appears one clock after the request.

There are two modes. In ternary mode the truth table is an 8-bit immediate, indexed by the old destination value and two sources. In binary mode the truth table is a 4-bit nibble taken from the low byte of a third register, and a select flag picks which nibble. A ternary request may also ask for a record: the unit then writes a 4-bit condition nibble that classifies the result against zero and carries a summary-overflow bit.

Top module: `bitlut_unit`

## Requirements
- R1: In ternary mode (`tern_mode`=1) each result bit i equals `imm_tbl[k]`, where k = {dst_old[i], src_a[i], src_b[i]} read as a 3-bit number with dst_old as the most significant bit, and bit 0 of `imm_tbl` is its least significant bit.
- R2: In binary mode (`tern_mode`=0) with `nib_hi`=0, each result bit i equals `tbl_reg[k]`, where k = {src_a[i], src_b[i]} with src_a as the more significant bit.
- R3: In binary mode with `nib_hi`=1, each result bit i equals `tbl_reg[4+k]`, with k formed as in R2. Bits 7..4 of `tbl_reg` therefore act as the table.
- R4: `res_valid` is high in the cycle after a clock edge that sampled `req_valid` high, and low otherwise. `result` changes only on an edge where `req_valid` is high, and it holds its value on every other edge.
- R5: A ternary request with `rec`=1 sets `flags_valid` for one cycle. It also loads `flags` as {neg, pos, zero, so}: flags[3]=1 when the result is negative as a signed XLEN-bit value, flags[2]=1 when it is greater than zero, and flags[1]=1 when it equals zero.
- R6: On a record write, flags[0] takes the value of `so_in` sampled with the request.
- R7: `rec` has no effect in binary mode, and none when `req_valid` is low. In those cases `flags_valid` stays low and `flags` keeps its previous value.
- R8: While `rst_n` is low, `res_valid`, `flags_valid`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request accepted this cycle |
| tern_mode | input | 1 | 1 selects ternary mode, 0 selects binary mode |
| dst_old | input | XLEN | Current destination value, the top index bit in ternary mode |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| tbl_reg | input | 8 | Low byte of the third register, which holds the binary tables |
| imm_tbl | input | 8 | Ternary truth table |
| nib_hi | input | 1 | Binary table select: 0 takes bits 3..0, 1 takes bits 7..4 |
| rec | input | 1 | Request a condition-flag update (ternary mode only) |
| so_in | input | 1 | Summary-overflow bit to copy into the flags |
| res_valid | output | 1 | Result valid |
| result | output | XLEN | Registered result |
| flags_valid | output | 1 | Flags written this cycle |
| flags | output | 4 | {negative, positive, zero, summary overflow} |

## Verification
The bench drives specific tables to expose particular faults. The table 0xF0 copies the old destination, so an index with swapped significance returns a source instead. Binary runs use tables whose two nibbles differ, so an inverted or ignored `nib_hi` gives the wrong nibble. Directed results of zero, all ones and the most positive value check that the sign bit is what decides between negative and positive, and that zero is reported only for an all-zero result. Idle cycles and binary requests with `rec` high come between flag writes, so a unit that updates the flags when it should not changes a value the bench expects to stay the same.

// File: rtl/bitlut_unit.sv
module bitlut_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            tern_mode,
  input  logic [XLEN-1:0] dst_old,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [7:0]      tbl_reg,
  input  logic [7:0]      imm_tbl,
  input  logic            nib_hi,
  input  logic            rec,
  input  logic            so_in,
  output logic            res_valid,
  output logic [XLEN-1:0] result,
  output logic            flags_valid,
  output logic [3:0]      flags
);

  logic [3:0]      tbl2;
  logic [XLEN-1:0] nxt;
  logic            wr_flags;
  logic            is_zero;
  logic            is_neg;

  assign tbl2 = nib_hi ? tbl_reg[7:4] : tbl_reg[3:0];

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign nxt[i] = tern_mode ? imm_tbl[{dst_old[i], src_a[i], src_b[i]}]
                              : tbl2[{src_a[i], src_b[i]}];
  end

  assign wr_flags = req_valid & rec & tern_mode;
  assign is_zero  = (nxt == '0);
  assign is_neg   = nxt[XLEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      flags_valid <= 1'b0;
      result      <= '0;
      flags       <= '0;
    end else begin
      res_valid   <= req_valid;
      flags_valid <= wr_flags;
      if (req_valid) result <= nxt;
      if (wr_flags)  flags  <= {is_neg, ~is_neg & ~is_zero, is_zero, so_in};
    end
  end

  AST_TERN_COPY_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tern_mode && imm_tbl == 8'hF0) |=> (result == $past(dst_old))); // R1
  AST_BIN_LO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tern_mode && !nib_hi && tbl_reg[3:0] == 4'hA) |=> (result == $past(src_b))); // R2
  AST_BIN_HI_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tern_mode && nib_hi && tbl_reg[7:4] == 4'hC) |=> (result == $past(src_a))); // R3
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(result))); // R4
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> ($countones(flags[3:1]) == 1 && res_valid)); // R5
  AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flags |=> (flags[0] == $past(so_in))); // R6
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rec && tern_mode) |=> (!flags_valid && $stable(flags))); // R7

endmodule

// File: tb/bitlut_unit_tb_top.sv
module bitlut_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            tern_mode = 1'b0;
  logic [XLEN-1:0] dst_old = '0;
  logic [XLEN-1:0] src_a = '0;
  logic [XLEN-1:0] src_b = '0;
  logic [7:0]      tbl_reg = '0;
  logic [7:0]      imm_tbl = '0;
  logic            nib_hi = 1'b0;
  logic            rec = 1'b0;
  logic            so_in = 1'b0;
  logic            res_valid;
  logic [XLEN-1:0] result;
  logic            flags_valid;
  logic [3:0]      flags;

  int checks = 0;
  int errors = 0;

  logic            m_rv = 1'b0;
  logic [XLEN-1:0] m_res = '0;
  logic            m_fv = 1'b0;
  logic [3:0]      m_flags = '0;

  always #4 clk = ~clk;

  bitlut_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tern_mode(tern_mode),
    .dst_old(dst_old), .src_a(src_a), .src_b(src_b), .tbl_reg(tbl_reg),
    .imm_tbl(imm_tbl), .nib_hi(nib_hi), .rec(rec), .so_in(so_in),
    .res_valid(res_valid), .result(result), .flags_valid(flags_valid), .flags(flags)
  );

  function automatic logic [XLEN-1:0] ref_lut(input logic tm, input logic [XLEN-1:0] d,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [7:0] imm,
      input logic [7:0] tr, input logic hi);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      int k;
      if (tm) begin
        k = 4 * int'(d[i]) + 2 * int'(a[i]) + int'(b[i]);
        r[i] = imm[k];
      end else begin
        k = 2 * int'(a[i]) + int'(b[i]);
        r[i] = hi ? tr[4 + k] : tr[k];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " res_valid"}, {63'd0, res_valid}, {63'd0, m_rv});
    chk({tag, " result"}, result, m_res);
    chk({tag, " flags_valid"}, {63'd0, flags_valid}, {63'd0, m_fv});
    chk({tag, " flags"}, {60'd0, flags}, {60'd0, m_flags});
  endtask

  task automatic step(input string tag, input logic v, input logic tm, input logic [XLEN-1:0] d,
      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b, input logic [7:0] imm,
      input logic [7:0] tr, input logic hi, input logic rc, input logic so);
    logic [XLEN-1:0] r;
    req_valid = v; tern_mode = tm; dst_old = d; src_a = a; src_b = b;
    imm_tbl = imm; tbl_reg = tr; nib_hi = hi; rec = rc; so_in = so;
    @(posedge clk);
    r = ref_lut(tm, d, a, b, imm, tr, hi);
    m_rv = v;
    if (v) m_res = r;
    m_fv = v && rc && tm;
    if (m_fv) begin
      if ($signed(r) < 0)      m_flags = {3'b100, so};
      else if ($signed(r) > 0) m_flags = {3'b010, so};
      else                     m_flags = {3'b001, so};
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] a, b, d;
    repeat (3) @(negedge clk);
    compare_all("R8 reset");
    rst_n = 1'b1;

    a = 64'hF0F0_1234_0000_FFFF; b = 64'hCCCC_AAAA_5555_3333; d = 64'h0123_4567_89AB_CDEF;
    step("R1 copy dst", 1, 1, d, a, b, 8'hF0, 8'h00, 0, 0, 0);
    step("R1 and3",     1, 1, d, a, b, 8'h80, 8'h00, 0, 0, 0);
    step("R1 xor3",     1, 1, d, a, b, 8'h96, 8'h00, 0, 0, 0);
    step("R2 copy b",   1, 0, d, a, b, 8'h00, 8'h3A, 0, 0, 0);
    step("R2 nand",     1, 0, d, a, b, 8'h00, 8'h57, 0, 0, 0);
    step("R3 copy a",   1, 0, d, a, b, 8'h00, 8'hC5, 1, 0, 0);
    step("R3 xor",      1, 0, d, a, b, 8'h00, 8'h69, 1, 0, 0);
    step("R4 idle",     0, 1, ~d, ~a, b, 8'hFF, 8'hFF, 0, 1, 1);
    step("R4 idle2",    0, 0, d, ~a, ~b, 8'h0F, 8'h0F, 1, 0, 0);
    step("R5 zero",     1, 1, d, a, b, 8'h00, 8'h00, 0, 1, 0);
    step("R5 neg",      1, 1, d, a, b, 8'hFF, 8'h00, 0, 1, 1);
    step("R5 pos",      1, 1, 64'h7FFF_FFFF_FFFF_FFFF, a, b, 8'hF0, 8'h00, 0, 1, 0);
    step("R6 so set",   1, 1, 64'h1, a, b, 8'hF0, 8'h00, 0, 1, 1);
    step("R7 binary rec", 1, 0, d, a, b, 8'h00, 8'h00, 0, 1, 0);
    step("R7 idle rec",   0, 1, d, a, b, 8'h00, 8'h00, 0, 1, 0);
    step("R5 min neg",  1, 1, 64'h8000_0000_0000_0000, a, b, 8'hF0, 8'h00, 0, 1, 0);

    for (int n = 0; n < 400; n++) begin
      logic tm;
      tm = $urandom_range(0, 1) == 1;
      step(tm ? "R1 random" : "R2 R3 random", $urandom_range(0, 3) != 0, tm, rnd64(), rnd64(), rnd64(),
           8'($urandom), 8'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    req_valid = 1'b1; rst_n = 1'b0;
    @(posedge clk);
    m_rv = 0; m_res = '0; m_fv = 0; m_flags = '0;
    @(negedge clk);
    compare_all("R8 reset again");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule